// File: doc/BRIEF.md
# SCSI Initiator Message-In Decoder

This block handles the message-in phase on the initiator side of a parallel SCSI bus. Once started, it takes the first message byte from the target. Each byte arrives while the target holds `req_i`, and the decoder answers with `ack_o`. The decoder sorts the byte into a message class and acts on it. For some classes it fetches further bytes, and for some it waits for the bus to go free. When it finishes, it returns to idle and pulses `done_o`.

Some outcomes update the command state. The decoder reports these on a one-cycle strobe that carries the new state code and, when a command completes, a result code. Events and errors appear on a code output with a one-cycle valid strobe. The decoder then stalls until the host acknowledges the code.

Extended messages are parsed by their length byte. The decoder passes only synchronous and wide transfer negotiation messages up to the host. Any other well-formed extended message gets an automatic reject handshake on message-out. This handshake repeats for as long as the target stays in message-out.

Top module: `msgin_dec`

## Requirements
- R1: After reset and whenever `busy_o` is low, `ack_o`, `atn_o`, `evt_valid_o` and `st_upd_o` are low. Every return to idle pulses `done_o` for one cycle.
- R2: A first byte of 0x07 raises event 10 while `ack_o` is still held, then releases `ack_o` and ends.
- R3: A first byte of 0x02 or 0x03 releases `ack_o` and ends. It raises no event and makes no state update.
- R4: A first byte of 0x04 releases `ack_o` at once. No state update happens before `bus_free_i` is seen high. Then `st_upd_o` pulses with `st_code_o` = 3 and `st_res_upd_o` low.
- R5: A first byte of 0x00 releases `ack_o` and waits for `bus_free_i`. Then `st_upd_o` pulses with `st_code_o` = 4, `st_res_upd_o` high and `st_res_o` = 0.
- R6: A first byte of 0x23 fetches one more byte into bits [7:0] of `ext_data_o` and then raises event 16.
- R7: Any first byte outside {0x00, 0x01, 0x02, 0x03, 0x04, 0x07, 0x23} raises error 1.
- R8: A first byte of 0x01 begins an extended message. Its following bytes land in `ext_data_o`: the length byte in bits [7:0] and the next bytes in bits [15:8], [23:16] and [31:24]. Length 3 with code 0x01 raises event 11 after the fourth byte.
- R9: An extended message with length 2 and code 0x03 raises event 15 after its third byte.
- R10: Length 1, or length 2 or 3 with a non-matching code, starts the reject sequence. The decoder raises `atn_o` and drops `ack_o`, then waits for `req_i` with `phase_i` = 3'b110 (message-out). It then drops `atn_o` and sends `dout_o` = 0x07 with `ack_o` high for one cycle. If the phase is still message-out one cycle after `ack_o` falls, the whole sequence runs again.
- R11: An extended length byte outside 1 to 3 raises error 5.
- R12: If `req_i` arrives while a message byte is expected and `phase_i` is not 3'b111 (message-in), the decoder raises error 4. The same error applies to a `req_i` during the reject wait when the phase is not message-out.
- R13: `evt_valid_o` is high for one cycle per code. `evt_code_o` holds its value, and the decoder stays busy and frozen until `evt_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin decoding a message (accepted in idle) |
| phase_i | input | 3 | Bus phase, 3'b111 message-in, 3'b110 message-out |
| req_i | input | 1 | Target request |
| rx_byte_i | input | 8 | Byte from target, valid with `req_i` |
| bus_free_i | input | 1 | Bus has gone free |
| evt_ack_i | input | 1 | Host acknowledges the pending code |
| ack_o | output | 1 | Initiator acknowledge |
| atn_o | output | 1 | Initiator attention |
| dout_o | output | 8 | Byte sent on message-out |
| busy_o | output | 1 | Decoder not idle |
| done_o | output | 1 | One-cycle pulse on return to idle |
| st_upd_o | output | 1 | State update strobe |
| st_code_o | output | SW | New state code |
| st_res_upd_o | output | 1 | Result is also written with this update |
| st_res_o | output | RW | Result code |
| ext_data_o | output | 8*EXT_N | Captured extended or residue bytes |
| evt_valid_o | output | 1 | Event code strobe |
| evt_code_o | output | CW | Event or error code |

## Verification
A misdecoded first byte shows up within two or three cycles of the rising `ack_o`, either as a wrong code on the event port or as a missing or extra state strobe. A byte counter that has drifted in the extended parser shows up as stored bytes in the wrong lanes. It can also show up as an event that fires one byte early, or as a decoder that hangs while it waits for a byte the target never sends. A broken retry loop is seen one cycle after `ack_o` falls in message-out, because `atn_o` either fails to come back or comes back when it should not.

// File: rtl/msgin_pkg.sv
package msgin_pkg;
  typedef enum logic [2:0] {
    K_CMPL, K_EXT, K_PTR, K_DISC, K_REJ, K_IWR, K_BAD
  } kind_e;

  localparam logic [2:0] PH_MSGOUT = 3'b110;
  localparam logic [2:0] PH_MSGIN  = 3'b111;

  localparam logic [7:0] B_CMPL = 8'h00;
  localparam logic [7:0] B_EXT  = 8'h01;
  localparam logic [7:0] B_SAVE = 8'h02;
  localparam logic [7:0] B_REST = 8'h03;
  localparam logic [7:0] B_DISC = 8'h04;
  localparam logic [7:0] B_REJ  = 8'h07;
  localparam logic [7:0] B_IWR  = 8'h23;
  localparam logic [7:0] X_SYNC = 8'h01;
  localparam logic [7:0] X_WIDE = 8'h03;

  localparam int EV_ERR_CMPL  = 1;
  localparam int EV_ERR_PHASE = 4;
  localparam int EV_ERR_EXT   = 5;
  localparam int EV_REJECTED  = 10;
  localparam int EV_SYNC      = 11;
  localparam int EV_WIDE      = 15;
  localparam int EV_RESIDUE   = 16;

  localparam int ST_DISC = 3;
  localparam int ST_DONE = 4;
  localparam int RES_OK  = 0;
endpackage

// File: rtl/msgin_class.sv
module msgin_class
  import msgin_pkg::*;
(
  input  logic [7:0] byte_i,
  output kind_e      kind_o
);
  always_comb begin
    unique case (byte_i)
      B_CMPL:         kind_o = K_CMPL;
      B_EXT:          kind_o = K_EXT;
      B_SAVE, B_REST: kind_o = K_PTR;
      B_DISC:         kind_o = K_DISC;
      B_REJ:          kind_o = K_REJ;
      B_IWR:          kind_o = K_IWR;
      default:        kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/msgin_evt_port.sv
module msgin_evt_port #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          post_i,
  input  logic [CW-1:0] code_i,
  input  logic          ack_i,
  output logic          valid_o,
  output logic [CW-1:0] code_o,
  output logic          done_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      pend_q  <= 1'b0;
    end else begin
      valid_o <= post_i;
      if (post_i) begin
        code_o <= code_i;
        pend_q <= 1'b1;
      end else if (pend_q && ack_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign done_o = pend_q & ack_i;
endmodule

// File: rtl/msgin_dec.sv
module msgin_dec
  import msgin_pkg::*;
#(
  parameter int CW    = 8,
  parameter int SW    = 3,
  parameter int RW    = 8,
  parameter int EXT_N = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         phase_i,
  input  logic               req_i,
  input  logic [7:0]         rx_byte_i,
  input  logic               bus_free_i,
  input  logic               evt_ack_i,
  output logic               ack_o,
  output logic               atn_o,
  output logic [7:0]         dout_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               st_upd_o,
  output logic [SW-1:0]      st_code_o,
  output logic               st_res_upd_o,
  output logic [RW-1:0]      st_res_o,
  output logic [8*EXT_N-1:0] ext_data_o,
  output logic               evt_valid_o,
  output logic [CW-1:0]      evt_code_o
);
  localparam int AW = $clog2(EXT_N);
  localparam int IW = $clog2(EXT_N + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_GET, S_DECODE, S_EXT, S_EVT_POST, S_EVT_WAIT, S_WAIT_FREE,
    S_REJ_ATN, S_REJ_WAIT, S_REJ_REL, S_REJ_LOOP, S_DONE
  } state_e;

  state_e          state_q, get_ret_q, evt_ret_q;
  logic            first_q;
  logic [IW-1:0]   idx_q;
  logic [7:0]      msg_q;
  logic [7:0]      ext_q [EXT_N];
  logic [CW-1:0]   evt_code_q;
  logic [SW-1:0]   wf_code_q;
  kind_e           kind;
  logic            ev_post, ev_done;
  logic [7:0]      len;

  msgin_class u_class (.byte_i(msg_q), .kind_o(kind));

  msgin_evt_port #(.CW(CW)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .post_i (ev_post),
    .code_i (evt_code_q),
    .ack_i  (evt_ack_i),
    .valid_o(evt_valid_o),
    .code_o (evt_code_o),
    .done_o (ev_done)
  );

  assign ev_post = (state_q == S_EVT_POST);
  assign busy_o  = (state_q != S_IDLE);
  assign len     = ext_q[0];

  for (genvar g = 0; g < EXT_N; g++) begin : g_ext
    assign ext_data_o[8*g +: 8] = ext_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      get_ret_q    <= S_DECODE;
      evt_ret_q    <= S_DONE;
      first_q      <= 1'b0;
      idx_q        <= '0;
      msg_q        <= '0;
      evt_code_q   <= '0;
      wf_code_q    <= '0;
      ack_o        <= 1'b0;
      atn_o        <= 1'b0;
      dout_o       <= '0;
      done_o       <= 1'b0;
      st_upd_o     <= 1'b0;
      st_code_o    <= '0;
      st_res_upd_o <= 1'b0;
      st_res_o     <= '0;
      for (int i = 0; i < EXT_N; i++) ext_q[i] <= '0;
    end else begin
      done_o       <= 1'b0;
      st_upd_o     <= 1'b0;
      st_res_upd_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          idx_q     <= '0;
          first_q   <= 1'b1;
          get_ret_q <= S_DECODE;
          state_q   <= S_GET;
        end
        S_GET: if (req_i) begin
          if (phase_i != PH_MSGIN) begin
            evt_code_q <= CW'(EV_ERR_PHASE);
            evt_ret_q  <= S_DONE;
            state_q    <= S_EVT_POST;
          end else begin
            ack_o   <= 1'b1;
            first_q <= 1'b0;
            if (first_q) msg_q <= rx_byte_i;
            else begin
              if (32'(idx_q) < EXT_N) ext_q[idx_q[AW-1:0]] <= rx_byte_i;
              idx_q <= idx_q + 1'b1;
            end
            state_q <= get_ret_q;
          end
        end
        S_DECODE: begin
          unique case (kind)
            K_REJ: begin
              evt_code_q <= CW'(EV_REJECTED);
              evt_ret_q  <= S_DONE;
              state_q    <= S_EVT_POST;
            end
            K_PTR: state_q <= S_DONE;
            K_DISC, K_CMPL: begin
              ack_o     <= 1'b0;
              wf_code_q <= (kind == K_DISC) ? SW'(ST_DISC) : SW'(ST_DONE);
              state_q   <= S_WAIT_FREE;
            end
            K_IWR: begin
              ack_o      <= 1'b0;
              evt_code_q <= CW'(EV_RESIDUE);
              evt_ret_q  <= S_DONE;
              get_ret_q  <= S_EVT_POST;
              state_q    <= S_GET;
            end
            K_EXT: begin
              ack_o     <= 1'b0;
              get_ret_q <= S_EXT;
              state_q   <= S_GET;
            end
            default: begin
              evt_code_q <= CW'(EV_ERR_CMPL);
              evt_ret_q  <= S_DONE;
              state_q    <= S_EVT_POST;
            end
          endcase
        end
        S_EXT: begin
          if (idx_q == IW'(1)) begin
            if (len >= 8'd1 && len <= 8'd3) begin
              ack_o   <= 1'b0;
              state_q <= S_GET;
            end else begin
              evt_code_q <= CW'(EV_ERR_EXT);
              evt_ret_q  <= S_DONE;
              state_q    <= S_EVT_POST;
            end
          end else if (8'(idx_q) == len + 8'd1) begin
            evt_ret_q <= S_DONE;
            if (len == 8'd3 && ext_q[1] == X_SYNC) begin
              evt_code_q <= CW'(EV_SYNC);
              state_q    <= S_EVT_POST;
            end else if (len == 8'd2 && ext_q[1] == X_WIDE) begin
              evt_code_q <= CW'(EV_WIDE);
              state_q    <= S_EVT_POST;
            end else begin
              state_q <= S_REJ_ATN;
            end
          end else begin
            ack_o   <= 1'b0;
            state_q <= S_GET;
          end
        end
        S_EVT_POST: state_q <= S_EVT_WAIT;
        S_EVT_WAIT: if (ev_done) state_q <= evt_ret_q;
        S_WAIT_FREE: if (bus_free_i) begin
          st_upd_o     <= 1'b1;
          st_code_o    <= wf_code_q;
          st_res_upd_o <= (wf_code_q == SW'(ST_DONE));
          st_res_o     <= RW'(RES_OK);
          state_q      <= S_DONE;
        end
        S_REJ_ATN: begin
          atn_o   <= 1'b1;
          ack_o   <= 1'b0;
          state_q <= S_REJ_WAIT;
        end
        S_REJ_WAIT: if (req_i) begin
          if (phase_i != PH_MSGOUT) begin
            evt_code_q <= CW'(EV_ERR_PHASE);
            evt_ret_q  <= S_DONE;
            state_q    <= S_EVT_POST;
          end else begin
            atn_o   <= 1'b0;
            dout_o  <= B_REJ;
            ack_o   <= 1'b1;
            state_q <= S_REJ_REL;
          end
        end
        S_REJ_REL: begin
          ack_o   <= 1'b0;
          state_q <= S_REJ_LOOP;
        end
        S_REJ_LOOP: state_q <= (phase_i == PH_MSGOUT) ? S_REJ_ATN : S_DONE;
        S_DONE: begin
          ack_o   <= 1'b0;
          atn_o   <= 1'b0;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msgin_dec_chk.sv
module msgin_dec_chk #(
  parameter int SW = 3,
  parameter int RW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_free_i,
  input logic          ack_o,
  input logic          atn_o,
  input logic [7:0]    dout_o,
  input logic          busy_o,
  input logic          st_upd_o,
  input logic [SW-1:0] st_code_o,
  input logic          st_res_upd_o,
  input logic [RW-1:0] st_res_o,
  input logic          evt_valid_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ack_o && !atn_o && !st_upd_o)); // R1
  AST_EVT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o); // R13
  AST_EVT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> busy_o); // R13
  AST_FREE_BEFORE_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_upd_o |-> $past(bus_free_i)); // R4
  AST_DISC_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_upd_o && !st_res_upd_o) |-> (st_code_o == SW'(3))); // R4
  AST_DONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_res_upd_o |-> (st_upd_o && st_code_o == SW'(4) && st_res_o == '0)); // R5
  AST_REJ_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $rose(ack_o) && $past(atn_o)) |-> (!atn_o && dout_o == 8'h07)); // R10
endmodule

bind msgin_dec msgin_dec_chk #(.SW(SW), .RW(RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_free_i  (bus_free_i),
  .ack_o       (ack_o),
  .atn_o       (atn_o),
  .dout_o      (dout_o),
  .busy_o      (busy_o),
  .st_upd_o    (st_upd_o),
  .st_code_o   (st_code_o),
  .st_res_upd_o(st_res_upd_o),
  .st_res_o    (st_res_o),
  .evt_valid_o (evt_valid_o)
);

// File: tb/tb_msgin_dec.sv
`timescale 1ns/1ps
module tb_msgin_dec;
  localparam logic [2:0] PH_IN  = 3'b111;
  localparam logic [2:0] PH_OUT = 3'b110;
  localparam logic [2:0] PH_ST  = 3'b011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, req_i = 1'b0, bus_free_i = 1'b0, evt_ack_i = 1'b0;
  logic [2:0]  phase_i = PH_IN;
  logic [7:0]  rx_byte_i = '0;
  logic        ack_o, atn_o, busy_o, done_o, st_upd_o, st_res_upd_o, evt_valid_o;
  logic [7:0]  dout_o, st_res_o, evt_code_o;
  logic [2:0]  st_code_o;
  logic [31:0] ext_data_o;

  int tests = 0, fails = 0, evt_cnt = 0, st_cnt = 0;
  bit prev_valid = 0;

  always #2.5 clk = ~clk;

  msgin_dec dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .phase_i(phase_i),
    .req_i(req_i), .rx_byte_i(rx_byte_i), .bus_free_i(bus_free_i),
    .evt_ack_i(evt_ack_i), .ack_o(ack_o), .atn_o(atn_o), .dout_o(dout_o),
    .busy_o(busy_o), .done_o(done_o), .st_upd_o(st_upd_o), .st_code_o(st_code_o),
    .st_res_upd_o(st_res_upd_o), .st_res_o(st_res_o), .ext_data_o(ext_data_o),
    .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // per-clock reference rules
  always @(negedge clk) if (rst_n) begin
    if (evt_valid_o) evt_cnt++;
    if (st_upd_o) st_cnt++;
    chk(!(evt_valid_o && prev_valid), "R13 strobe width", 2, 1);
    chk(busy_o || (!ack_o && !atn_o), "R1 idle outputs", int'({ack_o, atn_o}), 0);
    prev_valid = evt_valid_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_msg();
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
  endtask

  task automatic send_in(input logic [7:0] b, input string rq);
    int t = 0;
    while (ack_o && t < 50) begin tick(1); t++; end
    phase_i = PH_IN; rx_byte_i = b; req_i = 1'b1; t = 0;
    while (!ack_o && t < 50) begin tick(1); t++; end
    req_i = 1'b0;
    chk(ack_o, rq, int'(ack_o), 1);
  endtask

  task automatic take_evt(input int exp, input string rq, input int hold);
    int t = 0;
    while (!evt_valid_o && t < 100) begin tick(1); t++; end
    chk(evt_valid_o && evt_code_o == 8'(exp), rq, int'(evt_code_o), exp);
    tick(hold);
    evt_ack_i = 1'b1;
    tick(1);
    evt_ack_i = 1'b0;
  endtask

  task automatic wait_done(input string rq);
    int t = 0;
    while (!done_o && t < 100) begin tick(1); t++; end
    chk(done_o, rq, int'(done_o), 1);
    tick(1);
  endtask

  task automatic rej_round(input bit stay, input string rq);
    int t = 0;
    while (!atn_o && t < 50) begin tick(1); t++; end
    chk(atn_o && !ack_o, rq, int'({atn_o, ack_o}), 2);
    phase_i = PH_OUT; req_i = 1'b1; t = 0;
    while (!ack_o && t < 50) begin tick(1); t++; end
    req_i = 1'b0;
    chk(ack_o && !atn_o && dout_o == 8'h07, rq, int'(dout_o), 7);
    if (!stay) phase_i = PH_IN;
  endtask

  task automatic wait_st(input int code, input bit res, input string rq);
    int t = 0;
    while (!st_upd_o && t < 50) begin tick(1); t++; end
    chk(st_upd_o && st_code_o == 3'(code), rq, int'(st_code_o), code);
    chk(st_res_upd_o == res && (!res || st_res_o == 8'd0), rq, int'(st_res_upd_o), int'(res));
  endtask

  initial begin : watchdog
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int e0, s0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(!ack_o && !atn_o && !busy_o && !evt_valid_o && !st_upd_o, "R1 reset", int'(busy_o), 0);

    // R3 pointer messages
    for (int k = 2; k <= 3; k++) begin
      e0 = evt_cnt; s0 = st_cnt;
      begin_msg(); send_in(8'(k), "R3 accept"); wait_done("R3 done");
      chk(evt_cnt == e0 && st_cnt == s0 && !ack_o, "R3 no side effect", evt_cnt - e0, 0);
    end

    // R2 reject received
    begin_msg(); send_in(8'h07, "R2 accept");
    take_evt(10, "R2 event", 0);
    wait_done("R2 done");

    // R4 disconnect
    s0 = st_cnt;
    begin_msg(); send_in(8'h04, "R4 accept");
    tick(3);
    chk(!ack_o, "R4 ack released", int'(ack_o), 0);
    tick(6);
    chk(st_cnt == s0, "R4 waits bus free", st_cnt - s0, 0);
    bus_free_i = 1'b1;
    wait_st(3, 1'b0, "R4 state");
    bus_free_i = 1'b0;
    wait_done("R4 done");

    // R5 command complete
    begin_msg(); send_in(8'h00, "R5 accept");
    tick(4); bus_free_i = 1'b1;
    wait_st(4, 1'b1, "R5 state");
    bus_free_i = 1'b0;
    wait_done("R5 done");

    // R7 unknown byte
    begin_msg(); send_in(8'h55, "R7 accept");
    take_evt(1, "R7 error", 1);
    wait_done("R7 done");

    // R6 ignore wide residue
    begin_msg(); send_in(8'h23, "R6 accept"); send_in(8'h01, "R6 residue");
    take_evt(16, "R6 event", 0);
    chk(ext_data_o[7:0] == 8'h01, "R6 residue byte", int'(ext_data_o[7:0]), 1);
    wait_done("R6 done");

    // R8 synchronous negotiation
    begin_msg(); send_in(8'h01, "R8 a"); send_in(8'h03, "R8 b"); send_in(8'h01, "R8 c");
    send_in(8'h19, "R8 d"); send_in(8'h08, "R8 e");
    take_evt(11, "R8 event", 2);
    chk(ext_data_o == 32'h08190103, "R8 bytes", int'(ext_data_o), 32'h08190103);
    wait_done("R8 done");

    // R9 wide negotiation
    begin_msg(); send_in(8'h01, "R9 a"); send_in(8'h02, "R9 b"); send_in(8'h03, "R9 c");
    send_in(8'h01, "R9 d");
    take_evt(15, "R9 event", 0);
    chk(ext_data_o[23:0] == 24'h010302, "R9 bytes", int'(ext_data_o[23:0]), 24'h010302);
    wait_done("R9 done");

    // R10 length 1 -> single reject
    e0 = evt_cnt;
    begin_msg(); send_in(8'h01, "R10 a"); send_in(8'h01, "R10 b"); send_in(8'h44, "R10 c");
    rej_round(1'b0, "R10 round");
    wait_done("R10 done");
    chk(evt_cnt == e0, "R10 no event", evt_cnt - e0, 0);

    // R10 retry while message-out persists
    begin_msg(); send_in(8'h01, "R10 r a"); send_in(8'h01, "R10 r b"); send_in(8'h44, "R10 r c");
    rej_round(1'b1, "R10 retry first");
    rej_round(1'b0, "R10 retry second");
    wait_done("R10 retry done");

    // R10 length 3 with foreign code
    begin_msg(); send_in(8'h01, "R10 x a"); send_in(8'h03, "R10 x b"); send_in(8'h02, "R10 x c");
    send_in(8'hAA, "R10 x d"); send_in(8'hBB, "R10 x e");
    rej_round(1'b0, "R10 foreign code");
    wait_done("R10 foreign done");

    // R11 bad lengths
    begin_msg(); send_in(8'h01, "R11 a"); send_in(8'h05, "R11 b");
    take_evt(5, "R11 len 5", 0); wait_done("R11 done");
    begin_msg(); send_in(8'h01, "R11 c"); send_in(8'h00, "R11 d");
    take_evt(5, "R11 len 0", 0); wait_done("R11 done 0");

    // R12 wrong phase on first byte
    begin_msg();
    phase_i = PH_ST; rx_byte_i = 8'h00; req_i = 1'b1; tick(1); req_i = 1'b0;
    take_evt(4, "R12 first byte", 0); wait_done("R12 done a");
    phase_i = PH_IN;

    // R12 wrong phase on extended payload
    begin_msg(); send_in(8'h01, "R12 b");
    tick(2);
    phase_i = PH_ST; req_i = 1'b1; tick(1); req_i = 1'b0;
    take_evt(4, "R12 payload", 0); wait_done("R12 done b");
    phase_i = PH_IN;

    // R12 wrong phase during reject wait
    begin_msg(); send_in(8'h01, "R12 c"); send_in(8'h01, "R12 d"); send_in(8'h44, "R12 e");
    tick(3);
    chk(atn_o, "R12 atn before", int'(atn_o), 1);
    phase_i = PH_ST; req_i = 1'b1; tick(1); req_i = 1'b0;
    take_evt(4, "R12 reject phase", 0); wait_done("R12 done c");
    phase_i = PH_IN;

    // R13 stall until host ack
    begin_msg(); send_in(8'h07, "R13 accept");
    begin
      int t = 0;
      while (!evt_valid_o && t < 50) begin tick(1); t++; end
    end
    tick(12);
    chk(busy_o && ack_o && !done_o && evt_code_o == 8'd10, "R13 stalled", int'(evt_code_o), 10);
    evt_ack_i = 1'b1; tick(1); evt_ack_i = 1'b0;
    wait_done("R13 done");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule